// File: doc/BRIEF.md
# Unsigned Subtractor with Sign-Magnitude Result

This block takes two unsigned W-bit operands, a minuend `x` and a subtrahend `y`, and returns their difference as a magnitude plus a sign flag. It does not return a result that wraps around. The subtraction reuses a plain ripple adder. The subtrahend is inverted, and the +1 of its two's complement enters as the adder's carry-in, so the subtrahend passes through nothing but inverters before the adder.

The carry out of the top bit decides the outcome. When a carry is present, the minuend was at least as large as the subtrahend: the carry is dropped and the W-bit sum is the answer. When no carry is present, a borrow occurred and the raw sum is meaningless as an unsigned value. That raw sum is negated once more to recover the magnitude, and `neg` is raised. Two structures for this correcting negation can be chosen by parameter. One is a second adder pass that increments the inverted sum. The other is a prefix scan that keeps every bit up to and including the lowest 1 and inverts every bit above it. The block is purely combinational.

Top module: `unsigned_sub_sm`

## Requirements
- R1: When x >= y, neg is 0 and magnitude equals x - y.
- R2: When x < y, neg is 1 and magnitude equals y - x, which is never zero.
- R3: When x equals y, magnitude is 0 and neg is 0, for any operand value.
- R4: At the extremes the full W-bit range is used: x=0 with y=2^W-1 gives magnitude 2^W-1 with neg=1, and x=2^W-1 with y=0 gives magnitude 2^W-1 with neg=0.
- R5: The outputs depend only on the present inputs. They settle in the same time step as an input change, with no clock or held state.
- R6: The parameter NEG_STYLE picks the correcting negation: 0 selects the adder pass and 1 selects the lowest-one scan. Both choices give identical outputs for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | W | Unsigned minuend |
| y | input | W | Unsigned subtrahend |
| magnitude | output | W | Absolute value of x - y |
| neg | output | 1 | 1 when x < y |

## Verification
The embedded assertions check several relations whenever the inputs are known. Each ripple adder's sum and carry must match the arithmetic sum of its operands. Each correcting negation, added to its input, must give zero. At the top, the sign must agree with the operand order, a negative result must never have magnitude zero, and equal operands must give a clean zero. Some behaviour can only be shown by the bench's scenarios: the exact magnitudes at the range extremes, settling within the same time step, and agreement between the two negation variants. The bench sweeps every operand pair for the default width through both variants.

// File: rtl/sub_sm_pkg.sv
package sub_sm_pkg;

    // selects the structure used to negate the raw sum on a borrow
    typedef enum int {
        NEG_ADDER = 0,
        NEG_SCAN  = 1
    } neg_style_e;

endpackage

// File: rtl/sub_half_add.sv
module sub_half_add (
    input  logic a,
    input  logic b,
    output logic s,
    output logic c
);
    assign s = a ^ b;
    assign c = a & b;
endmodule

// File: rtl/sub_full_add.sv
module sub_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic s0;
    logic c0;
    logic c1;

    sub_half_add ha0_i (.a(a),  .b(b),  .s(s0), .c(c0));
    sub_half_add ha1_i (.a(s0), .b(ci), .s(s),  .c(c1));

    assign co = c0 | c1;
endmodule

// File: rtl/sub_ripple_add.sv
module sub_ripple_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int CW = W + 1;

    logic [W:0] carry_d;

    assign carry_d[0] = cin;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        sub_full_add fa_i (
            .a  (a[gi]),
            .b  (b[gi]),
            .ci (carry_d[gi]),
            .s  (sum[gi]),
            .co (carry_d[gi+1])
        );
    end

    assign cout = carry_d[W];

    // R1
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            add_sum_chk: assert ({cout, sum} == CW'(a) + CW'(b) + CW'(cin))
                else $error("ripple adder result mismatch");
        end
    end
endmodule

// File: rtl/sub_negate.sv
module sub_negate
    import sub_sm_pkg::*;
#(
    parameter int W         = 8,
    parameter int NEG_STYLE = NEG_ADDER
) (
    input  logic [W-1:0] v,
    output logic [W-1:0] nv
);
    if (NEG_STYLE == NEG_SCAN) begin : g_scan
        // keep bits through the lowest 1, invert those above it
        logic [W:0] seen_d;
        assign seen_d[0] = 1'b0;
        for (genvar gi = 0; gi < W; gi++) begin : g_bit
            assign nv[gi]       = v[gi] ^ seen_d[gi];
            assign seen_d[gi+1] = seen_d[gi] | v[gi];
        end
    end else begin : g_adder
        logic unused_co;
        sub_ripple_add #(.W(W)) inc_i (
            .a    (~v),
            .b    ('0),
            .cin  (1'b1),
            .sum  (nv),
            .cout (unused_co)
        );
    end

    // R6
    always_comb begin
        if (!$isunknown(v)) begin
            neg_zero_chk: assert (W'(nv + v) == '0)
                else $error("negation does not cancel its input");
        end
    end
endmodule

// File: rtl/unsigned_sub_sm.sv
module unsigned_sub_sm
    import sub_sm_pkg::*;
#(
    parameter int W         = 8,
    parameter int NEG_STYLE = NEG_ADDER
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] magnitude,
    output logic         neg
);
    typedef struct packed {
        logic [W-1:0] mag;
        logic         neg;
    } result_t;

    logic [W-1:0] y_inv_d;
    logic [W-1:0] raw_d;
    logic         end_carry_d;
    logic [W-1:0] fixed_d;
    result_t      res_d;

    assign y_inv_d = ~y;

    // x + ~y + 1: the +1 of the two's complement rides on carry-in
    sub_ripple_add #(.W(W)) main_add_i (
        .a    (x),
        .b    (y_inv_d),
        .cin  (1'b1),
        .sum  (raw_d),
        .cout (end_carry_d)
    );

    sub_negate #(.W(W), .NEG_STYLE(NEG_STYLE)) fix_i (
        .v  (raw_d),
        .nv (fixed_d)
    );

    always_comb begin
        res_d.neg = ~end_carry_d;
        res_d.mag = end_carry_d ? raw_d : fixed_d;
    end

    assign magnitude = res_d.mag;
    assign neg       = res_d.neg;

    always_comb begin
        if (!$isunknown({x, y})) begin
            // R1
            sign_pos_chk: assert (neg || (x >= y && W'(magnitude + y) == x))
                else $error("non-negative result inconsistent");
            // R2
            sign_neg_chk: assert (!neg || (x < y && magnitude != '0 && W'(magnitude + x) == y))
                else $error("negative result inconsistent");
            // R3
            equal_zero_chk: assert (x != y || (magnitude == '0 && !neg))
                else $error("equal operands not zero");
        end
    end
endmodule

// File: tb/unsigned_sub_sm_tb.sv
module unsigned_sub_sm_tb_top;
    localparam int W      = 8;
    localparam int MAXV   = (1 << W) - 1;
    localparam int LIMIT  = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic [W-1:0] mag_a;
    logic         neg_a;
    logic [W-1:0] mag_b;
    logic         neg_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    unsigned_sub_sm #(.W(W), .NEG_STYLE(0)) dut_i (
        .x(x), .y(y), .magnitude(mag_a), .neg(neg_a)
    );

    unsigned_sub_sm #(.W(W), .NEG_STYLE(1)) dut_scan_i (
        .x(x), .y(y), .magnitude(mag_b), .neg(neg_b)
    );

    always @(posedge clk) cycles <= cycles + 1;

    task automatic expect_out(input string tag, input logic [W-1:0] m, input logic n,
                              input int em, input int en);
        checks++;
        if (int'(m) != em || int'(n) != en) begin
            errors++;
            $display("FAIL %s x=%0d y=%0d got mag=%0d neg=%0d exp mag=%0d neg=%0d",
                     tag, x, y, m, n, em, en);
        end
    endtask

    // behavioural model: signed integer difference split into sign and size
    task automatic apply(input string tag, input int xv, input int yv, input bit same_step);
        int d;
        int em;
        int en;
        @(posedge clk);
        x = W'(xv);
        y = W'(yv);
        d  = xv - yv;
        en = (d < 0) ? 1 : 0;
        em = (d < 0) ? -d : d;
        if (same_step) begin
            #0.5;
            expect_out("R5", mag_a, neg_a, em, en);
        end
        @(negedge clk);
        expect_out(tag, mag_a, neg_a, em, en);
        expect_out("R6", mag_b, neg_b, em, en);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero inputs give a clean zero
        expect_out("R3", mag_a, neg_a, 0, 0);
        rst = 1'b0;

        apply("R1", 77, 23, 1'b1);
        apply("R1", 200, 1, 1'b0);
        apply("R2", 19, 30, 1'b1);
        apply("R2", 1, 200, 1'b0);
        apply("R3", 0, 0, 1'b0);
        apply("R3", 128, 128, 1'b1);
        apply("R3", MAXV, MAXV, 1'b0);
        apply("R4", 0, MAXV, 1'b1);
        apply("R4", MAXV, 0, 1'b1);
        apply("R2", 127, 128, 1'b0);
        apply("R1", 128, 127, 1'b0);

        // full sweep of every operand pair
        for (int i = 0; i <= MAXV; i++) begin
            for (int j = 0; j <= MAXV; j++) begin
                apply((i >= j) ? "R1" : "R2", i, j, 1'b0);
            end
        end
        finish_run();
    end

    initial begin
        wait (cycles >= LIMIT);
        errors++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
        finish_run();
    end
endmodule